// File: doc/BRIEF.md
# Region-Tagged Address Translation Buffer

This block turns a 64-bit virtual address into a physical address through a small fully associative translation buffer. The three most significant address bits name one of eight region registers; the 24-bit region identifier held there, not the address bits themselves, is the tag searched together with the virtual page number. Each region therefore covers 2^61 bytes, and software can map up to 2^24 distinct address spaces by loading different identifiers.

Every buffer entry carries its own page size, anywhere from 4 KB to 256 MB in powers of two. The split between page number and page offset moves with the size of the entry being compared. A matching entry still has to pass a privilege level test, a read/write/execute test and, when the caller enables it, a protection key test against four key registers. There is no table walker. When nothing matches, the block reports a miss fault, and software inserts the translation and retries.

Software fills the buffer through an insert port and removes ranges through a purge port. A lookup is evaluated combinationally and its result is registered, so the response appears on the cycle after the request.

Top module: `rtlb_xlate`

## Requirements
- R1: The region number is lk_va[63:61]. It selects one of eight region registers, and that register's identifier is the identifier compared during the search. The region registers reset to identifier 0 and are loaded through rr_we/rr_idx/rr_rid.
- R2: An entry matches only when it is valid, its stored identifier equals the selected region identifier, and its page number equals lk_va[60:ps], where ps is that entry's log2 page size. The bits below ps take no part in the comparison.
- R3: On a clean hit, rsp_pa takes bits [47:ps] from the entry's physical page and bits [ps-1:0] unchanged from lk_va.
- R4: Each entry stores its own ps. An insert with ins_ps below 12 is stored as 12, and one above 28 is stored as 28.
- R5: An insert writes the lowest-numbered invalid entry. When every entry is valid, it writes the entry under a round-robin pointer. The pointer resets to 0 and advances by one, wrapping, only on inserts that replace a valid entry.
- R6: When nothing matches, rsp_miss=1, rsp_hit=0 and rsp_pa=0.
- R7: On a hit, rsp_acc_flt=1 when lk_pl is numerically greater than the entry's pl, or when the entry lacks the permission for lk_acc: 2'b00 read needs r, 2'b01 write needs w, 2'b10 and 2'b11 execute need x. rsp_pa is 0 whenever any fault is raised.
- R8: With pk_chk_en=1, the entry's key must equal the key of a valid key register, or rsp_key_miss=1. If the key is found but a matching register has the disable bit for lk_acc set (pk_rd, pk_wd, pk_xd), rsp_key_perm=1. With pk_chk_en=0, keys have no effect.
- R9: At most one fault is raised per response, in the priority miss, then access fault, then key miss, then key permission. rsp_hit=1 means an entry matched, even when a lower-priority fault is raised.
- R10: A purge with rid, address and ps invalidates every valid entry with the same identifier whose page range overlaps the purged range. The two ranges overlap when the addresses agree above the larger of the two page sizes.
- R11: A lookup strobed on lk_en gives rsp_valid=1 and its result on the next cycle. In cycles without a strobe, all response outputs are 0. A lookup sees the buffer state from before any insert or purge in the same cycle.
- R12: Protection key registers reset invalid, so with checking enabled every hit reports a key miss until a key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_we | input | 1 | Region register write strobe |
| rr_idx | input | 3 | Region register index |
| rr_rid | input | 24 | Region identifier to write |
| pk_we | input | 1 | Key register write strobe |
| pk_idx | input | 2 | Key register index |
| pk_valid | input | 1 | Valid bit to write |
| pk_key | input | 24 | Key value to write |
| pk_rd | input | 1 | Read disable bit to write |
| pk_wd | input | 1 | Write disable bit to write |
| pk_xd | input | 1 | Execute disable bit to write |
| ins_en | input | 1 | Insert strobe |
| ins_va | input | 64 | Virtual address of the inserted page |
| ins_rid | input | 24 | Region identifier of the inserted entry |
| ins_pa | input | 48 | Physical address of the page |
| ins_ps | input | 5 | log2 page size (clamped to 12..28) |
| ins_pl | input | 2 | Least privileged level allowed |
| ins_r | input | 1 | Read permitted |
| ins_w | input | 1 | Write permitted |
| ins_x | input | 1 | Execute permitted |
| ins_key | input | 24 | Protection key of the entry |
| prg_en | input | 1 | Purge strobe |
| prg_va | input | 64 | Address inside the purged range |
| prg_rid | input | 24 | Region identifier to purge |
| prg_ps | input | 5 | log2 size of the purged range |
| lk_en | input | 1 | Lookup strobe |
| lk_va | input | 64 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 1x execute |
| lk_pl | input | 2 | Current privilege level |
| pk_chk_en | input | 1 | Enable protection key checking |
| rsp_valid | output | 1 | Response valid, one cycle after lk_en |
| rsp_hit | output | 1 | An entry matched |
| rsp_pa | output | 48 | Physical address on a clean hit, else 0 |
| rsp_miss | output | 1 | Miss fault |
| rsp_acc_flt | output | 1 | Privilege or permission fault |
| rsp_key_miss | output | 1 | Protection key not present |
| rsp_key_perm | output | 1 | Protection key forbids the access |

## Verification
The bench sweeps every page size from 4 KB to 256 MB and probes both the last bytes inside each page and the first byte past it. A design that split page number and offset at a fixed boundary would leak wrong physical bits or hit on the neighbouring page. It overfills the buffer by one entry and then purges and refills, to catch a victim choice that skips free slots or moves the round-robin pointer when it should not. Purges are tried with the wrong identifier, on an adjacent range, on a contained smaller range and on an enclosing larger range, so a purge that ignores the identifier or compares at the wrong granularity shows up. Every mix of privilege level, entry level, permission bits and access type is checked, and so is each key disable pattern, with and without key checking. A wrong fault priority or a physical address that leaks out on a fault would be seen there.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;

  localparam int VA_W   = 64;
  localparam int RN_W   = 3;
  localparam int NUM_RR = 8;
  localparam int PG_LO  = 12;
  localparam int VPN_HI = 60;
  localparam int VPN_W  = VPN_HI - PG_LO + 1;
  localparam int PS_W   = 5;
  localparam int PS_MIN = 12;
  localparam int PS_MAX = 28;

  localparam logic [1:0] ACC_RD = 2'b00;
  localparam logic [1:0] ACC_WR = 2'b01;

  function automatic logic [PS_W-1:0] ps_clamp(input logic [PS_W-1:0] ps);
    if (int'(ps) < PS_MIN) return PS_W'(PS_MIN);
    if (int'(ps) > PS_MAX) return PS_W'(PS_MAX);
    return ps;
  endfunction

  function automatic logic [PS_W-1:0] ps_max(input logic [PS_W-1:0] a,
                                             input logic [PS_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // set where a page-number bit takes part in the compare
  function automatic logic [VPN_W-1:0] vpn_mask(input logic [PS_W-1:0] ps);
    logic [VPN_W-1:0] m;
    for (int i = 0; i < VPN_W; i++) m[i] = ((i + PG_LO) >= int'(ps));
    return m;
  endfunction

endpackage

// File: rtl/rtlb_region_file.sv
module rtlb_region_file
  import rtlb_pkg::*;
#(
  parameter int RID_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RN_W-1:0]  wr_idx,
  input  logic [RID_W-1:0] wr_rid,
  input  logic [RN_W-1:0]  rd_idx,
  output logic [RID_W-1:0] rd_rid
);

  logic [NUM_RR-1:0][RID_W-1:0] rid_q;

  for (genvar g = 0; g < NUM_RR; g++) begin : g_rr
    logic             ld;
    logic [RID_W-1:0] nxt;

    assign ld = wr_en && (wr_idx == RN_W'(g));

    always_comb begin
      nxt = rid_q[g];
      if (ld) nxt = wr_rid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rid_q[g] <= '0;
      else        rid_q[g] <= nxt;
    end
  end

  assign rd_rid = rid_q[rd_idx];

endmodule

// File: rtl/rtlb_key_unit.sv
module rtlb_key_unit #(
  parameter int NUM_KEYS = 4,
  parameter int KEY_W    = 24,
  parameter int KIDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [KIDX_W-1:0] wr_idx,
  input  logic              wr_valid,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic              wr_rd,
  input  logic              wr_wd,
  input  logic              wr_xd,
  input  logic [KEY_W-1:0]  chk_key,
  input  logic [1:0]        chk_acc,
  output logic              found,
  output logic              denied
);

  logic [NUM_KEYS-1:0]            kv_q;
  logic [NUM_KEYS-1:0][KEY_W-1:0] key_q;
  logic [NUM_KEYS-1:0][2:0]       dis_q;   // {xd, wd, rd}
  logic [NUM_KEYS-1:0]            hit_v;
  logic [NUM_KEYS-1:0]            den_v;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    logic ld;
    logic nxt_v;

    assign ld = wr_en && (wr_idx == KIDX_W'(g));

    always_comb begin
      nxt_v = kv_q[g];
      if (ld) nxt_v = wr_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kv_q[g] <= 1'b0;
      else        kv_q[g] <= nxt_v;
    end

    always_ff @(posedge clk) begin
      if (ld) begin
        key_q[g] <= wr_key;
        dis_q[g] <= {wr_xd, wr_wd, wr_rd};
      end
    end

    assign hit_v[g] = kv_q[g] && (key_q[g] == chk_key);

    always_comb begin
      unique case (chk_acc)
        2'b00:   den_v[g] = hit_v[g] && dis_q[g][0];
        2'b01:   den_v[g] = hit_v[g] && dis_q[g][1];
        default: den_v[g] = hit_v[g] && dis_q[g][2];
      endcase
    end
  end

  assign found  = |hit_v;
  assign denied = |den_v;

endmodule

// File: rtl/rtlb_entry_array.sv
module rtlb_entry_array
  import rtlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int RID_W   = 24,
  parameter int KEY_W   = 24,
  parameter int PPN_W   = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [RID_W-1:0] ins_rid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [PS_W-1:0]  ins_ps,
  input  logic [1:0]       ins_pl,
  input  logic             ins_r,
  input  logic             ins_w,
  input  logic             ins_x,
  input  logic [KEY_W-1:0] ins_key,
  input  logic             prg_en,
  input  logic [RID_W-1:0] prg_rid,
  input  logic [VPN_W-1:0] prg_vpn,
  input  logic [PS_W-1:0]  prg_ps,
  input  logic [RID_W-1:0] lk_rid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [PS_W-1:0]  lk_ps,
  output logic [1:0]       lk_pl,
  output logic             lk_r,
  output logic             lk_w,
  output logic             lk_x,
  output logic [KEY_W-1:0] lk_key
);

  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int ATT_W = PPN_W + PS_W + 2 + 3 + KEY_W;

  logic [NUM_ENT-1:0]             e_valid;
  logic [NUM_ENT-1:0]             e_match;
  logic [NUM_ENT-1:0]             e_purge;
  logic [NUM_ENT-1:0]             e_load;
  logic [NUM_ENT-1:0][RID_W-1:0]  e_rid;
  logic [NUM_ENT-1:0][VPN_W-1:0]  e_vpn;
  logic [NUM_ENT-1:0][PS_W-1:0]   e_ps;
  logic [NUM_ENT-1:0][ATT_W-1:0]  e_att;

  logic [IDX_W-1:0] rr_q, rr_nxt, free_idx, victim;
  logic             any_free;
  logic [ATT_W-1:0] ins_att, sel_att;

  assign ins_att = {ins_ppn, ins_ps, ins_pl, ins_r, ins_w, ins_x, ins_key};

  // victim choice: lowest free slot, else round-robin
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!e_valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    victim = any_free ? free_idx : rr_q;
  end

  always_comb begin
    rr_nxt = rr_q;
    if (ins_en && !any_free) begin
      if (rr_q == IDX_W'(NUM_ENT - 1)) rr_nxt = '0;
      else                             rr_nxt = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_nxt;
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic nxt_valid;

    assign e_match[g] = e_valid[g] && (e_rid[g] == lk_rid) &&
                        (((e_vpn[g] ^ lk_vpn) & vpn_mask(e_ps[g])) == '0);

    assign e_purge[g] = prg_en && e_valid[g] && (e_rid[g] == prg_rid) &&
                        (((e_vpn[g] ^ prg_vpn) &
                          vpn_mask(ps_max(e_ps[g], prg_ps))) == '0);

    assign e_load[g] = ins_en && (victim == IDX_W'(g));

    always_comb begin
      nxt_valid = e_valid[g];
      if (e_purge[g]) nxt_valid = 1'b0;
      if (e_load[g])  nxt_valid = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_valid[g] <= 1'b0;
      else        e_valid[g] <= nxt_valid;
    end

    always_ff @(posedge clk) begin
      if (e_load[g]) begin
        e_rid[g] <= ins_rid;
        e_vpn[g] <= ins_vpn;
        e_ps[g]  <= ins_ps;
        e_att[g] <= ins_att;
      end
    end
  end

  // lowest matching index wins
  always_comb begin
    lk_hit  = 1'b0;
    sel_att = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (e_match[i]) begin
        lk_hit  = 1'b1;
        sel_att = e_att[i];
      end
    end
  end

  assign {lk_ppn, lk_ps, lk_pl, lk_r, lk_w, lk_x, lk_key} = sel_att;

endmodule

// File: rtl/rtlb_xlate.sv
module rtlb_xlate
  import rtlb_pkg::*;
#(
  parameter int NUM_ENT  = 16,
  parameter int RID_W    = 24,
  parameter int KEY_W    = 24,
  parameter int PA_W     = 48,
  parameter int NUM_KEYS = 4,
  parameter int KIDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rr_we,
  input  logic [2:0]        rr_idx,
  input  logic [RID_W-1:0]  rr_rid,
  input  logic              pk_we,
  input  logic [KIDX_W-1:0] pk_idx,
  input  logic              pk_valid,
  input  logic [KEY_W-1:0]  pk_key,
  input  logic              pk_rd,
  input  logic              pk_wd,
  input  logic              pk_xd,
  input  logic              ins_en,
  input  logic [63:0]       ins_va,
  input  logic [RID_W-1:0]  ins_rid,
  input  logic [PA_W-1:0]   ins_pa,
  input  logic [4:0]        ins_ps,
  input  logic [1:0]        ins_pl,
  input  logic              ins_r,
  input  logic              ins_w,
  input  logic              ins_x,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic              prg_en,
  input  logic [63:0]       prg_va,
  input  logic [RID_W-1:0]  prg_rid,
  input  logic [4:0]        prg_ps,
  input  logic              lk_en,
  input  logic [63:0]       lk_va,
  input  logic [1:0]        lk_acc,
  input  logic [1:0]        lk_pl,
  input  logic              pk_chk_en,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_miss,
  output logic              rsp_acc_flt,
  output logic              rsp_key_miss,
  output logic              rsp_key_perm
);

  localparam int PPN_W = PA_W - PG_LO;

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_ni <= rst_s0;
    end
  end

  logic [RN_W-1:0]  lk_rn;
  logic [RID_W-1:0] cur_rid;
  logic             e_hit, e_r, e_w, e_x;
  logic [PPN_W-1:0] e_ppn;
  logic [PS_W-1:0]  e_ps;
  logic [1:0]       e_pl;
  logic [KEY_W-1:0] e_key;
  logic             key_found, key_denied;

  assign lk_rn = lk_va[VA_W-1 -: RN_W];

  rtlb_region_file #(.RID_W(RID_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_ni),
    .wr_en  (rr_we),
    .wr_idx (rr_idx),
    .wr_rid (rr_rid),
    .rd_idx (lk_rn),
    .rd_rid (cur_rid)
  );

  rtlb_entry_array #(
    .NUM_ENT(NUM_ENT), .RID_W(RID_W), .KEY_W(KEY_W), .PPN_W(PPN_W)
  ) u_ent (
    .clk     (clk),
    .rst_n   (rst_ni),
    .ins_en  (ins_en),
    .ins_rid (ins_rid),
    .ins_vpn (ins_va[VPN_HI:PG_LO]),
    .ins_ppn (ins_pa[PA_W-1:PG_LO]),
    .ins_ps  (ps_clamp(ins_ps)),
    .ins_pl  (ins_pl),
    .ins_r   (ins_r),
    .ins_w   (ins_w),
    .ins_x   (ins_x),
    .ins_key (ins_key),
    .prg_en  (prg_en),
    .prg_rid (prg_rid),
    .prg_vpn (prg_va[VPN_HI:PG_LO]),
    .prg_ps  (ps_clamp(prg_ps)),
    .lk_rid  (cur_rid),
    .lk_vpn  (lk_va[VPN_HI:PG_LO]),
    .lk_hit  (e_hit),
    .lk_ppn  (e_ppn),
    .lk_ps   (e_ps),
    .lk_pl   (e_pl),
    .lk_r    (e_r),
    .lk_w    (e_w),
    .lk_x    (e_x),
    .lk_key  (e_key)
  );

  rtlb_key_unit #(
    .NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W), .KIDX_W(KIDX_W)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_en    (pk_we),
    .wr_idx   (pk_idx),
    .wr_valid (pk_valid),
    .wr_key   (pk_key),
    .wr_rd    (pk_rd),
    .wr_wd    (pk_wd),
    .wr_xd    (pk_xd),
    .chk_key  (e_key),
    .chk_acc  (lk_acc),
    .found    (key_found),
    .denied   (key_denied)
  );

  // physical address: page bits from the entry, offset from the request
  logic [PA_W-1:0] off_mask, xl_pa;
  always_comb begin
    for (int i = 0; i < PA_W; i++) off_mask[i] = (i < int'(e_ps));
    xl_pa = ({e_ppn, {PG_LO{1'b0}}} & ~off_mask) | (lk_va[PA_W-1:0] & off_mask);
  end

  logic perm_ok, pl_bad;
  always_comb begin
    unique case (lk_acc)
      ACC_RD:  perm_ok = e_r;
      ACC_WR:  perm_ok = e_w;
      default: perm_ok = e_x;
    endcase
    pl_bad = (lk_pl > e_pl);
  end

  logic            n_valid, n_hit, n_miss, n_acc, n_kmiss, n_kperm;
  logic [PA_W-1:0] n_pa;

  always_comb begin
    n_valid = 1'b0;
    n_hit   = 1'b0;
    n_miss  = 1'b0;
    n_acc   = 1'b0;
    n_kmiss = 1'b0;
    n_kperm = 1'b0;
    n_pa    = '0;
    if (lk_en) begin
      n_valid = 1'b1;
      n_hit   = e_hit;
      if (!e_hit)                          n_miss  = 1'b1;
      else if (pl_bad || !perm_ok)         n_acc   = 1'b1;
      else if (pk_chk_en && !key_found)    n_kmiss = 1'b1;
      else if (pk_chk_en && key_denied)    n_kperm = 1'b1;
      else                                 n_pa    = xl_pa;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_acc_flt  <= 1'b0;
      rsp_key_miss <= 1'b0;
      rsp_key_perm <= 1'b0;
      rsp_pa       <= '0;
    end else begin
      rsp_valid    <= n_valid;
      rsp_hit      <= n_hit;
      rsp_miss     <= n_miss;
      rsp_acc_flt  <= n_acc;
      rsp_key_miss <= n_kmiss;
      rsp_key_perm <= n_kperm;
      rsp_pa       <= n_pa;
    end
  end

endmodule

// File: rtl/rtlb_xlate_chk.sv
module rtlb_xlate_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_en,
  input logic            pk_chk_en,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_miss,
  input logic            rsp_acc_flt,
  input logic            rsp_key_miss,
  input logic            rsp_key_perm
);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> rsp_valid);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_acc_flt &&
                !rsp_key_miss && !rsp_key_perm && rsp_pa == '0));

  // R9
  single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_miss, rsp_acc_flt, rsp_key_miss, rsp_key_perm}) <= 1);

  // R6
  miss_no_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_hit && rsp_pa == '0));

  // R7
  fault_no_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_acc_flt || rsp_key_miss || rsp_key_perm) |-> (rsp_hit && rsp_pa == '0));

  // R8
  key_fault_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_key_miss || rsp_key_perm) |-> $past(pk_chk_en));

endmodule

bind rtlb_xlate rtlb_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_ni),
  .lk_en        (lk_en),
  .pk_chk_en    (pk_chk_en),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_pa       (rsp_pa),
  .rsp_miss     (rsp_miss),
  .rsp_acc_flt  (rsp_acc_flt),
  .rsp_key_miss (rsp_key_miss),
  .rsp_key_perm (rsp_key_perm)
);

// File: tb/rtlb_xlate_tb.sv
module rtlb_xlate_tb;

  localparam logic [23:0] RB = 24'h000100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rr_we;      logic [2:0]  rr_idx;  logic [23:0] rr_rid;
  logic        pk_we;      logic [1:0]  pk_idx;  logic pk_valid;
  logic [23:0] pk_key;     logic pk_rd, pk_wd, pk_xd;
  logic        ins_en;     logic [63:0] ins_va;  logic [23:0] ins_rid;
  logic [47:0] ins_pa;     logic [4:0]  ins_ps;  logic [1:0]  ins_pl;
  logic        ins_r, ins_w, ins_x;               logic [23:0] ins_key;
  logic        prg_en;     logic [63:0] prg_va;  logic [23:0] prg_rid;
  logic [4:0]  prg_ps;
  logic        lk_en;      logic [63:0] lk_va;   logic [1:0]  lk_acc;
  logic [1:0]  lk_pl;      logic pk_chk_en;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_acc_flt, rsp_key_miss, rsp_key_perm;
  logic [47:0] rsp_pa;

  int n_chk = 0;
  int n_err = 0;
  logic [5:0]  g_fl;
  logic [47:0] g_pa;

  always #5 clk = ~clk;

  rtlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .rr_we(rr_we), .rr_idx(rr_idx), .rr_rid(rr_rid),
    .pk_we(pk_we), .pk_idx(pk_idx), .pk_valid(pk_valid), .pk_key(pk_key),
    .pk_rd(pk_rd), .pk_wd(pk_wd), .pk_xd(pk_xd),
    .ins_en(ins_en), .ins_va(ins_va), .ins_rid(ins_rid), .ins_pa(ins_pa),
    .ins_ps(ins_ps), .ins_pl(ins_pl), .ins_r(ins_r), .ins_w(ins_w),
    .ins_x(ins_x), .ins_key(ins_key),
    .prg_en(prg_en), .prg_va(prg_va), .prg_rid(prg_rid), .prg_ps(prg_ps),
    .lk_en(lk_en), .lk_va(lk_va), .lk_acc(lk_acc), .lk_pl(lk_pl),
    .pk_chk_en(pk_chk_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .rsp_miss(rsp_miss), .rsp_acc_flt(rsp_acc_flt),
    .rsp_key_miss(rsp_key_miss), .rsp_key_perm(rsp_key_perm)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] base_va(input int p);
    return (64'(p % 8) << 61) | (64'(p) << 32);
  endfunction

  function automatic logic [47:0] base_pa(input int p);
    return 48'(64'(p - 11) << 28);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_rr(input logic [2:0] idx, input logic [23:0] rid);
    @(negedge clk); rr_we = 1'b1; rr_idx = idx; rr_rid = rid;
    @(negedge clk); rr_we = 1'b0;
  endtask

  task automatic wr_pk(input logic [1:0] idx, input logic v, input logic [23:0] k,
                       input logic [2:0] dis);
    @(negedge clk);
    pk_we = 1'b1; pk_idx = idx; pk_valid = v; pk_key = k;
    {pk_xd, pk_wd, pk_rd} = dis;
    @(negedge clk); pk_we = 1'b0;
  endtask

  task automatic ins(input logic [63:0] va, input logic [23:0] rid, input logic [47:0] pa,
                     input logic [4:0] ps, input logic [1:0] pl, input logic [2:0] rwx,
                     input logic [23:0] key);
    @(negedge clk);
    ins_en = 1'b1; ins_va = va; ins_rid = rid; ins_pa = pa; ins_ps = ps;
    ins_pl = pl; {ins_r, ins_w, ins_x} = rwx; ins_key = key;
    @(negedge clk); ins_en = 1'b0;
  endtask

  task automatic prg(input logic [63:0] va, input logic [23:0] rid, input logic [4:0] ps);
    @(negedge clk); prg_en = 1'b1; prg_va = va; prg_rid = rid; prg_ps = ps;
    @(negedge clk); prg_en = 1'b0;
  endtask

  // flags {valid, hit, miss, acc, kmiss, kperm}
  task automatic do_lk(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] pl,
                       input logic pke);
    @(negedge clk);
    lk_en = 1'b1; lk_va = va; lk_acc = acc; lk_pl = pl; pk_chk_en = pke;
    @(negedge clk);
    lk_en = 1'b0;
    g_fl = {rsp_valid, rsp_hit, rsp_miss, rsp_acc_flt, rsp_key_miss, rsp_key_perm};
    g_pa = rsp_pa;
  endtask

  task automatic exp_hit(input string tag, input logic [63:0] va, input logic [47:0] pa);
    do_lk(va, 2'b00, 2'b00, 1'b0);
    chk({tag, " flags"}, 64'(g_fl), 64'(6'b110000));
    chk({tag, " pa"}, 64'(g_pa), 64'(pa));
  endtask

  task automatic exp_miss(input string tag, input logic [63:0] va);
    do_lk(va, 2'b00, 2'b00, 1'b0);
    chk({tag, " flags"}, 64'(g_fl), 64'(6'b101000));
    chk({tag, " pa"}, 64'(g_pa), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rr_we = 0; rr_idx = 0; rr_rid = 0;
    pk_we = 0; pk_idx = 0; pk_valid = 0; pk_key = 0; pk_rd = 0; pk_wd = 0; pk_xd = 0;
    ins_en = 0; ins_va = 0; ins_rid = 0; ins_pa = 0; ins_ps = 0; ins_pl = 0;
    ins_r = 0; ins_w = 0; ins_x = 0; ins_key = 0;
    prg_en = 0; prg_va = 0; prg_rid = 0; prg_ps = 0;
    lk_en = 0; lk_va = 0; lk_acc = 0; lk_pl = 0; pk_chk_en = 0;
    do_reset();

    // reset state: idle outputs, empty buffer
    chk("R11 idle after reset", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_pa}), 64'd0);
    exp_miss("R6 empty buffer", 64'h0000_0000_0000_1000);
    @(negedge clk);
    chk("R11 idle cycle after response", 64'({rsp_valid, rsp_miss}), 64'd0);

    for (int r = 0; r < 8; r++) wr_rr(3'(r), RB + 24'(r));

    // R4 R3 R2: one entry per page size, 12..28; 17th insert replaces slot 0
    for (int p = 12; p <= 28; p++)
      ins(base_va(p), RB + 24'(p % 8), base_pa(p), 5'(p), 2'd3, 3'b111, 24'd0);

    exp_miss("R5 round robin replaced oldest", base_va(12) + 64'h10);
    for (int p = 13; p <= 28; p++) begin
      logic [63:0] m, off;
      m   = (64'd1 << p) - 1;
      off = 64'hABCD_EF12_3 & m;
      exp_hit($sformatf("R3 R4 ps=%0d inside", p), base_va(p) + off,
              base_pa(p) | 48'(off));
      exp_hit($sformatf("R3 ps=%0d last byte", p), base_va(p) + m,
              base_pa(p) | 48'(m));
      exp_miss($sformatf("R2 ps=%0d next page", p), base_va(p) + m + 1);
      // same page bits, other region number: identifier differs
      exp_miss($sformatf("R1 ps=%0d other region", p),
               (base_va(p) ^ (64'd1 << 61)));
    end

    // R1: rewriting a region register redirects the search
    wr_rr(3'd5, 24'hFFFFFF);
    exp_miss("R1 region rid changed", base_va(21));
    wr_rr(3'd5, RB + 24'd5);
    exp_hit("R1 region rid restored", base_va(21), base_pa(21));

    // R10: small purge inside a larger page
    prg(base_va(20) + 64'h3000, RB + 24'd4, 5'd12);
    exp_miss("R10 contained purge", base_va(20));
    exp_hit("R10 neighbour kept", base_va(22), base_pa(22));

    // R5: freed slot used first, pointer not moved
    ins(base_va(20), RB + 24'd4, base_pa(20), 5'd20, 2'd3, 3'b111, 24'd0);
    ins(64'h0000_0070_0000_0000, RB, 48'h7770_0000_0000, 5'd12, 2'd3, 3'b111, 24'd0);
    exp_hit("R5 refill into free slot", base_va(20), base_pa(20));
    exp_miss("R5 pointer advanced once", base_va(13));
    exp_hit("R5 next slot untouched", base_va(14), base_pa(14));
    exp_hit("R5 new entry", 64'h0000_0070_0000_0ABC, 48'h7770_0000_0ABC);

    // R10: wrong rid and adjacent range leave entry, enclosing range removes it
    prg(base_va(21), RB + 24'd6, 5'd28);
    exp_hit("R10 rid mismatch kept", base_va(21), base_pa(21));
    prg(base_va(21) + (64'd1 << 21), RB + 24'd5, 5'd12);
    exp_hit("R10 adjacent kept", base_va(21), base_pa(21));
    prg(base_va(21), RB + 24'd5, 5'd28);
    exp_miss("R10 enclosing purge", base_va(21));

    // second phase from reset
    do_reset();
    // R1: region registers reset to identifier 0
    ins(64'hC000_0001_0000_0000, 24'd0, 48'h0000_0055_5000, 5'd12, 2'd3, 3'b111, 24'd0);
    exp_hit("R1 reset rid zero", 64'hC000_0001_0000_0123, 48'h0000_0055_5123);
    // R4 clamps
    ins(64'h2000_0050_0000_0000, 24'd0, 48'h0001_0000_0000, 5'd31, 2'd3, 3'b111, 24'd0);
    exp_hit("R4 clamp high", 64'h2000_0050_0FFF_FFF0, 48'h0001_0FFF_FFF0);
    ins(64'h4000_0060_0000_0000, 24'd0, 48'h0000_0777_0000, 5'd5, 2'd3, 3'b111, 24'd0);
    exp_hit("R4 clamp low inside", 64'h4000_0060_0000_0FFF, 48'h0000_0777_0FFF);
    exp_miss("R4 clamp low next page", 64'h4000_0060_0000_1000);

    // R7 sweep: entry pl x rwx x access x current pl
    for (int epl = 0; epl < 4; epl++) begin
      for (int rwx = 0; rwx < 8; rwx++) begin
        prg(64'h6000_0010_0000_0000, 24'd0, 5'd12);
        ins(64'h6000_0010_0000_0000, 24'd0, 48'h0000_0ABC_D000, 5'd12,
            2'(epl), 3'(rwx), 24'd0);
        for (int acc = 0; acc < 4; acc++) begin
          for (int cpl = 0; cpl < 4; cpl++) begin
            logic ok, bad;
            ok  = (acc == 0) ? rwx[2] : (acc == 1) ? rwx[1] : rwx[0];
            bad = (cpl > epl) || !ok;
            do_lk(64'h6000_0010_0000_0123, 2'(acc), 2'(cpl), 1'b0);
            chk($sformatf("R7 epl=%0d rwx=%0d acc=%0d pl=%0d flags", epl, rwx, acc, cpl),
                64'(g_fl), 64'({1'b1, 1'b1, 1'b0, bad, 1'b0, 1'b0}));
            chk($sformatf("R7 epl=%0d rwx=%0d acc=%0d pl=%0d pa", epl, rwx, acc, cpl),
                64'(g_pa), bad ? 64'd0 : 64'h0ABC_D123);
          end
        end
      end
    end

    // key checks
    ins(64'h8000_0020_0000_0000, 24'd0, 48'h0000_1234_0000, 5'd16, 2'd3, 3'b111, 24'h00ABCD);
    ins(64'h8000_0030_0000_0000, 24'd0, 48'h0000_5678_0000, 5'd16, 2'd3, 3'b011, 24'h00ABCD);
    do_lk(64'h8000_0020_0000_0042, 2'b00, 2'd0, 1'b1);
    chk("R12 keys invalid after reset", 64'(g_fl), 64'(6'b110010));
    do_lk(64'h8000_0030_0000_0042, 2'b00, 2'd0, 1'b1);
    chk("R9 access fault outranks key miss", 64'(g_fl), 64'(6'b110100));
    do_lk(64'h8000_0020_0000_0042, 2'b00, 2'd0, 1'b0);
    chk("R8 keys ignored when disabled", 64'(g_fl), 64'(6'b110000));
    wr_pk(2'd1, 1'b1, 24'h000001, 3'b000);
    do_lk(64'h8000_0020_0000_0042, 2'b01, 2'd0, 1'b1);
    chk("R8 other key only", 64'(g_fl), 64'(6'b110010));
    for (int dis = 0; dis < 8; dis++) begin
      wr_pk(2'd2, 1'b1, 24'h00ABCD, 3'(dis));
      for (int acc = 0; acc < 3; acc++) begin
        logic den;
        den = (acc == 0) ? dis[0] : (acc == 1) ? dis[1] : dis[2];
        do_lk(64'h8000_0020_0000_0042, 2'(acc), 2'd1, 1'b1);
        chk($sformatf("R8 dis=%0d acc=%0d flags", dis, acc), 64'(g_fl),
            64'({1'b1, 1'b1, 1'b0, 1'b0, 1'b0, den}));
        chk($sformatf("R8 dis=%0d acc=%0d pa", dis, acc), 64'(g_pa),
            den ? 64'd0 : 64'h1234_0042);
      end
    end
    do_lk(64'h8000_0020_0000_0042, 2'b10, 2'd0, 1'b0);
    chk("R8 disabled check ignores deny", 64'(g_fl), 64'(6'b110000));
    wr_pk(2'd2, 1'b0, 24'h00ABCD, 3'b000);
    do_lk(64'h8000_0020_0000_0042, 2'b00, 2'd0, 1'b1);
    chk("R8 invalidated key", 64'(g_fl), 64'(6'b110010));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule